// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by walking a radix-512, four-level translation table held in memory. A translation request carries the virtual address and the kind of access: write, instruction fetch and user mode, where a request with none of these is a supervisor read. The walker starts from a root table base supplied on an input. It reads one 64-bit entry per level over a simple request/response memory port and stops early when a middle-level entry maps a large page.

Each walk ends with exactly one single-cycle pulse. A `done` pulse comes with the physical address, the page size and the permissions merged across every entry visited. A `fault` pulse comes with a cause code. Only one walk runs at a time. While `busy` is high, new requests are ignored. Each memory read must be answered before the next one is issued.

Top module: `pt_walker`

## Requirements
- R1: The first entry read goes to root_base[51:12]*4096 + VA[47:39]*8. Each later read uses the table base from the previous entry (entry[51:12]*4096) plus 8 times the next index, taking VA[38:30], VA[29:21] and VA[20:12] in that order.
- R2: A walk that reaches the fourth-level entry ends with `done`, page_size 0 (4 KiB) and pa_out = {entry[51:12], VA[11:0]}, after exactly four memory reads.
- R3: A present entry with bit 7 set at the second level ends the walk after two reads with page_size 2 (1 GiB) and pa_out = {entry[51:30], VA[29:0]}.
- R4: A present entry with bit 7 set at the third level ends the walk after three reads with page_size 1 (2 MiB) and pa_out = {entry[51:21], VA[20:0]}.
- R5: An entry with bit 0 clear ends the walk with fault_cause 2 (not present), and no further memory read is issued.
- R6: fault_cause 3 (reserved) is raised when bit 7 is set in a root-level or fourth-level entry, or when a large-page frame base has nonzero bits between bit 12 and its page-size boundary.
- R7: A write access faults with cause 4 (protection) unless bit 1 is set in every entry visited. A read of the same mapping completes.
- R8: A user access faults with cause 4 unless bit 2 is set in every entry visited. A supervisor access of the same mapping completes.
- R9: An instruction fetch faults with cause 4 if bit 63 is set in any entry visited. A data access of the same mapping completes.
- R10: If VA[63:48] is not a copy of VA[47], `fault` with cause 1 is raised in the cycle after the request, with no memory read.
- R11: `busy` stays high from acceptance until the end pulse. Requests made while busy are ignored. Every mem_req_valid pulse is a single cycle, and the next one comes only after mem_rsp_valid.
- R12: After reset, busy, done, fault and mem_req_valid are low. `done` and `fault` are single-cycle pulses and are never high together.
- R13: On `done`, perm_w is the AND of bit 1 over the visited entries, perm_u is the AND of bit 2, and perm_nx is the OR of bit 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 52 | Physical base of the root table; bits [11:0] are ignored |
| req_valid | input | 1 | Translation request strobe, taken when busy is low |
| req_va | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is made in user mode |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | One-cycle read request for one entry |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation failed |
| fault_cause | output | 3 | 1 non-canonical, 2 not present, 3 reserved, 4 protection |
| pa_out | output | 52 | Translated physical address |
| page_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| perm_w | output | 1 | Merged write permission |
| perm_u | output | 1 | Merged user permission |
| perm_nx | output | 1 | Merged no-execute flag |

## Verification
The bench uses the default parameters: 48-bit virtual addresses, 52-bit physical addresses, 9-bit indices and 4 KiB pages. With these values all four levels, both large-page sizes and the canonical-form check can be reached with a handful of sparse table entries. The memory model answers two cycles after each read request, which opens a window in which the bench drives a competing request and probes the busy blocking. The model keeps a log of the read addresses, so the bench can check the number of reads and the first read address for each outcome.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    FC_NONE     = 3'd0,
    FC_NONCANON = 3'd1,
    FC_ABSENT   = 3'd2,
    FC_RSVD     = 3'd3,
    FC_PROT     = 3'd4
  } fault_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } walk_state_e;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_HUGE    = 7;
  localparam int BIT_NOEXEC  = 63;

endpackage

// File: rtl/pt_index_sel.sv
module pt_index_sel #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  parameter int LVL_W  = 2
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PA_W-1:0]  tbl_base,
  output logic [PA_W-1:0]  ent_addr
);
  localparam int ENT_B = OFF_W - IDX_W;

  logic [IDX_W-1:0] idx_arr [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = va[OFF_W + g*IDX_W +: IDX_W];
  end

  assign ent_addr = {tbl_base[PA_W-1:OFF_W], idx_arr[lvl], {ENT_B{1'b0}}};

endmodule

// File: rtl/pt_perm_acc.sv
module pt_perm_acc (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic ent_w,
  input  logic ent_u,
  input  logic ent_nx,
  output logic merged_w,
  output logic merged_u,
  output logic merged_nx
);
  logic acc_w, acc_u, acc_nx;

  assign merged_w  = acc_w  & ent_w;
  assign merged_u  = acc_u  & ent_u;
  assign merged_nx = acc_nx | ent_nx;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_w  <= 1'b1;
      acc_u  <= 1'b1;
      acc_nx <= 1'b0;
    end else if (step) begin
      acc_w  <= merged_w;
      acc_u  <= merged_u;
      acc_nx <= merged_nx;
    end
  end

  a_r7_write_sticky: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_w) |-> $past(clr));
  a_r8_user_sticky: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_u) |-> $past(clr));
  a_r9_nx_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(acc_nx) |-> $past(clr));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ENT_W  = 64,
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PA_W-1:0]  root_base,
  input  logic             req_valid,
  input  logic [ENT_W-1:0] req_va,
  input  logic             req_write,
  input  logic             req_exec,
  input  logic             req_user,
  output logic             busy,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [2:0]       fault_cause,
  output logic [PA_W-1:0]  pa_out,
  output logic [1:0]       page_size,
  output logic             perm_w,
  output logic             perm_u,
  output logic             perm_nx
);
  localparam int LVL_W = $clog2(LEVELS);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);
  localparam logic [PA_W-1:0] PG_MASK = ~({PA_W{1'b1}} << OFF_W);
  localparam int HI_W = ENT_W - VA_W + 1;

  walk_state_e      state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, ex_q, us_q;

  assign busy = (state_q != ST_IDLE);

  // canonical-form test on the raw request
  logic [HI_W-1:0] va_hi;
  logic            noncanon;
  assign va_hi    = req_va[ENT_W-1:VA_W-1];
  assign noncanon = !((&va_hi) || !(|va_hi));

  logic accept, rsp;
  assign accept = req_valid && !busy;
  assign rsp    = (state_q == ST_WAIT) && mem_rsp_valid;

  // entry decode
  logic            ent_present, ent_huge;
  logic [PA_W-1:0] ent_frame, low_mask, leaf_pa;
  logic            misalign, huge_bad, is_leaf, rsvd, viol;
  int unsigned     split;

  assign ent_present = mem_rsp_data[BIT_PRESENT];
  assign ent_huge    = mem_rsp_data[BIT_HUGE];
  assign ent_frame   = {mem_rsp_data[PA_W-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    split    = OFF_W + int'(lvl_q) * IDX_W;
    low_mask = ~({PA_W{1'b1}} << split);
    misalign = |(ent_frame & low_mask & ~PG_MASK);
    huge_bad = ent_huge && ((lvl_q == TOP_LVL) || (lvl_q == '0));
    is_leaf  = (lvl_q == '0) || ent_huge;
    rsvd     = huge_bad || (ent_huge && misalign);
    leaf_pa  = (ent_frame & ~low_mask) | (PA_W'(va_q) & low_mask);
  end

  // permission merging
  logic m_w, m_u, m_nx;

  pt_perm_acc u_perm (
    .clk       (clk),
    .rst       (rst),
    .clr       (accept && !noncanon),
    .step      (rsp && ent_present && !rsvd && !is_leaf),
    .ent_w     (mem_rsp_data[BIT_WRITE]),
    .ent_u     (mem_rsp_data[BIT_USER]),
    .ent_nx    (mem_rsp_data[BIT_NOEXEC]),
    .merged_w  (m_w),
    .merged_u  (m_u),
    .merged_nx (m_nx)
  );

  assign viol = (wr_q && !m_w) || (us_q && !m_u) || (ex_q && m_nx);

  // entry address for the next read
  logic [VA_W-1:0]  sel_va;
  logic [LVL_W-1:0] sel_lvl;
  logic [PA_W-1:0]  sel_base, nxt_addr;

  assign sel_va   = busy ? va_q : req_va[VA_W-1:0];
  assign sel_lvl  = busy ? (lvl_q - 1'b1) : TOP_LVL;
  assign sel_base = busy ? ent_frame : root_base;

  pt_index_sel #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .LEVELS (LEVELS),
    .LVL_W  (LVL_W)
  ) u_idx (
    .va       (sel_va),
    .lvl      (sel_lvl),
    .tbl_base (sel_base),
    .ent_addr (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      lvl_q         <= '0;
      va_q          <= '0;
      wr_q          <= 1'b0;
      ex_q          <= 1'b0;
      us_q          <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done          <= 1'b0;
      fault         <= 1'b0;
      fault_cause   <= FC_NONE;
      pa_out        <= '0;
      page_size     <= '0;
      perm_w        <= 1'b0;
      perm_u        <= 1'b0;
      perm_nx       <= 1'b0;
    end else begin
      done          <= 1'b0;
      fault         <= 1'b0;
      mem_req_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (noncanon) begin
              fault       <= 1'b1;
              fault_cause <= FC_NONCANON;
            end else begin
              va_q          <= req_va[VA_W-1:0];
              wr_q          <= req_write;
              ex_q          <= req_exec;
              us_q          <= req_user;
              lvl_q         <= TOP_LVL;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= nxt_addr;
              state_q       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_present) begin
              fault       <= 1'b1;
              fault_cause <= FC_ABSENT;
              state_q     <= ST_IDLE;
            end else if (rsvd) begin
              fault       <= 1'b1;
              fault_cause <= FC_RSVD;
              state_q     <= ST_IDLE;
            end else if (is_leaf) begin
              state_q <= ST_IDLE;
              if (viol) begin
                fault       <= 1'b1;
                fault_cause <= FC_PROT;
              end else begin
                done        <= 1'b1;
                fault_cause <= FC_NONE;
                pa_out      <= leaf_pa;
                page_size   <= 2'(lvl_q);
                perm_w      <= m_w;
                perm_u      <= m_u;
                perm_nx     <= m_nx;
              end
            end else begin
              lvl_q         <= lvl_q - 1'b1;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= nxt_addr;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r12_done_fault_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_req_while_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);
  a_r11_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  a_r10_noncanon: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && noncanon) |=>
      (fault && fault_cause == FC_NONCANON && !mem_req_valid));
  a_r5_absent: assert property (@(posedge clk) disable iff (rst)
    (rsp && !mem_rsp_data[BIT_PRESENT]) |=>
      (fault && fault_cause == FC_ABSENT && !mem_req_valid));

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [51:0] root_base = 52'h1000;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0, req_exec = 1'b0, req_user = 1'b0;
  logic        busy, mem_req_valid, mem_rsp_valid;
  logic [51:0] mem_req_addr, pa_out;
  logic [63:0] mem_rsp_data;
  logic        done, fault, perm_w, perm_u, perm_nx;
  logic [2:0]  fault_cause;
  logic [1:0]  page_size;

  always #5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst(rst), .root_base(root_base), .req_valid(req_valid),
    .req_va(req_va), .req_write(req_write), .req_exec(req_exec), .req_user(req_user),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
    .fault(fault), .fault_cause(fault_cause), .pa_out(pa_out), .page_size(page_size),
    .perm_w(perm_w), .perm_u(perm_u), .perm_nx(perm_nx)
  );

  // sparse memory model, two-cycle latency
  logic [63:0] mem [logic [51:0]];
  logic        pend = 1'b0;
  logic [51:0] paddr = '0;
  int          lat = 0, reads = 0, dones = 0;
  logic [51:0] rlog [64];

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (done) dones <= dones + 1;
    if (mem_req_valid) begin
      pend <= 1'b1; paddr <= mem_req_addr; lat <= 1;
      rlog[reads[5:0]] <= mem_req_addr; reads <= reads + 1;
    end else if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid <= 1'b1; mem_rsp_data <= rd(paddr); pend <= 1'b0;
      end else lat <= lat - 1;
    end
  end

  int tests = 0, fails = 0;
  localparam logic [63:0] F_OK = 64'h7, F_HUGE = 64'h80, F_NX = 64'h8000_0000_0000_0000;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkva(input logic [8:0] a, b, c, d, input logic [11:0] off);
    logic [47:0] v;
    v = {a, b, c, d, off};
    return {{16{v[47]}}, v};
  endfunction

  task automatic put(input logic [63:0] a, input logic [63:0] d);
    mem[a[51:0]] = d;
  endtask

  task automatic chain(input int i4, i3, i2, i1, input logic [63:0] f4, f3, f2, f1, input logic [63:0] frame);
    put(64'h1000 + i4*8, 64'h2000 | f4);
    put(64'h2000 + i3*8, 64'h3000 | f3);
    put(64'h3000 + i2*8, 64'h4000 | f2);
    put(64'h4000 + i1*8, frame | f1);
  endtask

  logic r_done, r_fault; logic [2:0] r_cause; logic [51:0] r_pa, r_first;
  logic [1:0] r_psz; logic r_w, r_u, r_nx; int r_reads, r_wait;

  task automatic run(input logic [63:0] va, input logic w, x, u);
    int rd0;
    @(negedge clk);
    rd0 = reads;
    req_va = va; req_write = w; req_exec = x; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_wait = 0;
    while (!(done || fault) && r_wait < 200) begin @(negedge clk); r_wait++; end
    r_done = done; r_fault = fault; r_cause = fault_cause; r_pa = pa_out; r_psz = page_size;
    r_w = perm_w; r_u = perm_u; r_nx = perm_nx;
    r_reads = reads - rd0; r_first = rlog[rd0[5:0]];
  endtask

  task automatic t_reset();
    chk("R12", "busy", busy, 0); chk("R12", "done", done, 0);
    chk("R12", "fault", fault, 0); chk("R12", "mem_req_valid", mem_req_valid, 0);
  endtask

  task automatic t_4k();
    mem.delete();
    chain(1, 2, 3, 4, F_OK, F_OK, F_OK, F_OK, 64'h123_4567_8000);
    run(mkva(1, 2, 3, 4, 12'habc), 1, 0, 1);
    chk("R2", "done", r_done, 1); chk("R2", "pa", r_pa, 52'h123_4567_8abc);
    chk("R2", "page_size", r_psz, 0); chk("R2", "reads", r_reads, 4);
    chk("R1", "first addr", r_first, 52'h1008);
    chk("R13", "perms", {r_w, r_u, r_nx}, 3'b110);
    @(negedge clk);
    chk("R12", "done pulse", done, 0);
  endtask

  task automatic t_2m();
    mem.delete();
    chain(1, 2, 3, 4, F_OK, F_OK, F_OK, F_OK, 64'h5000);
    put(64'h3000 + 5*8, 64'h8020_0000 | F_OK | F_HUGE);
    run(mkva(1, 2, 5, 9'h11, 12'h123), 0, 0, 0);
    chk("R4", "done", r_done, 1); chk("R4", "pa", r_pa, 52'h8021_1123);
    chk("R4", "page_size", r_psz, 1); chk("R4", "reads", r_reads, 3);
  endtask

  task automatic t_1g();
    mem.delete();
    put(64'h1000 + 1*8, 64'h2000 | F_OK);
    put(64'h2000 + 6*8, 64'h1_4000_0000 | F_OK | F_HUGE | F_NX);
    run(mkva(1, 6, 7, 8, 12'h009), 0, 0, 0);
    chk("R3", "done", r_done, 1); chk("R3", "pa", r_pa, 52'h1_40E0_8009);
    chk("R3", "page_size", r_psz, 2); chk("R3", "reads", r_reads, 2);
    chk("R13", "nx merged", r_nx, 1);
    run(mkva(1, 6, 7, 8, 12'h009), 0, 1, 0);
    chk("R9", "exec on nx 1G", {r_fault, r_cause}, {1'b1, 3'd4});
  endtask

  task automatic t_absent();
    mem.delete();
    chain(1, 2, 3, 4, F_OK, F_OK, F_OK, F_OK, 64'h5000);
    run(mkva(1, 2, 9, 4, 0), 0, 0, 0);
    chk("R5", "fault", {r_fault, r_cause}, {1'b1, 3'd2}); chk("R5", "reads", r_reads, 3);
  endtask

  task automatic t_noncanon();
    run(64'h0000_8000_0000_0000, 0, 0, 0);
    chk("R10", "fault", {r_fault, r_cause}, {1'b1, 3'd1});
    chk("R10", "reads", r_reads, 0); chk("R10", "latency", r_wait, 0);
  endtask

  task automatic t_rsvd();
    mem.delete();
    put(64'h1000 + 3*8, 64'h4000_0000 | F_OK | F_HUGE);
    run(mkva(3, 0, 0, 0, 0), 0, 0, 0);
    chk("R6", "huge root", {r_fault, r_cause, r_reads[3:0]}, {1'b1, 3'd3, 4'd1});
    chain(1, 2, 3, 5, F_OK, F_OK, F_OK, F_OK | F_HUGE, 64'h9000);
    run(mkva(1, 2, 3, 5, 0), 0, 0, 0);
    chk("R6", "huge leaf", {r_fault, r_cause, r_reads[3:0]}, {1'b1, 3'd3, 4'd4});
    put(64'h3000 + 6*8, 64'h8020_1000 | F_OK | F_HUGE);
    run(mkva(1, 2, 6, 0, 0), 0, 0, 0);
    chk("R6", "misaligned 2M", {r_fault, r_cause}, {1'b1, 3'd3});
  endtask

  task automatic t_prot();
    mem.delete();
    chain(1, 2, 3, 4, F_OK, 64'h5, F_OK, F_OK, 64'h7000);
    run(mkva(1, 2, 3, 4, 0), 1, 0, 0);
    chk("R7", "write no W", {r_fault, r_cause}, {1'b1, 3'd4});
    run(mkva(1, 2, 3, 4, 0), 0, 0, 0);
    chk("R7", "read ok", {r_done, r_w}, 2'b10);
    mem.delete();
    chain(1, 2, 3, 4, F_OK, F_OK, 64'h3, F_OK, 64'h7000);
    run(mkva(1, 2, 3, 4, 0), 0, 0, 1);
    chk("R8", "user no U", {r_fault, r_cause}, {1'b1, 3'd4});
    run(mkva(1, 2, 3, 4, 0), 0, 0, 0);
    chk("R8", "supervisor ok", {r_done, r_u}, 2'b10);
    mem.delete();
    chain(1, 2, 3, 4, F_OK, F_OK, F_OK, F_OK | F_NX, 64'h7000);
    run(mkva(1, 2, 3, 4, 0), 0, 1, 0);
    chk("R9", "exec nx", {r_fault, r_cause}, {1'b1, 3'd4});
    run(mkva(1, 2, 3, 4, 0), 0, 0, 0);
    chk("R9", "data ok", r_done, 1);
  endtask

  task automatic t_busy();
    int rd0, d0;
    mem.delete();
    chain(1, 2, 3, 4, F_OK, F_OK, F_OK, F_OK, 64'h6000);
    chain(1, 2, 3, 7, F_OK, F_OK, F_OK, F_OK, 64'hA000);
    @(negedge clk);
    rd0 = reads; d0 = dones;
    req_va = mkva(1, 2, 3, 4, 12'h10); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    chk("R11", "busy", busy, 1);
    req_va = mkva(1, 2, 3, 7, 12'h20); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk("R11", "reads", reads - rd0, 4); chk("R11", "dones", dones - d0, 1);
    chk("R11", "pa", pa_out, 52'h6010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_4k();
    t_2m();
    t_1g();
    t_absent();
    t_noncanon();
    t_rsvd();
    t_prot();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule